// File: doc/BRIEF.md
# Serial Control Register Loader

This block is a write-only serial slave that fills a bank of 8-bit control registers. A host pulls the active-low select line, clocks bits in on the serial data line, and releases select to end the frame. The bit clock, select and data pins are brought into the block clock domain through a short synchronizer, and bits are taken on detected rising edges of the bit clock. Each frame opens with an 8-bit header made of a 7-bit device identity and a direction bit. A pointer byte follows, and then any number of data bytes. The registers' committed contents are presented side by side on one wide output bus.

The pointer can step forward on its own after each data byte. The register space is split into two runs, 01h-08h and 09h-11h, and stepping never carries from one run into the next. A freeze flag held in one register lets the host prepare several registers so that the new values reach the output bus in the same clock cycle.

Top module: `spi_wr_port`

## Requirements
- R1: The block takes a bit on each rising edge of `sclk` while `csN` is low, most significant bit first. Every frame is aligned to the falling edge of `csN`.
- R2: The first byte of a frame must be 30h: identity 0011000 in bits 7:1 and the write direction 0 in bit 0. Any other first byte makes the block ignore the rest of the frame, and no register changes.
- R3: In the second byte, bit 7 enables stepping and bits 4:0 hold the register address. Bits 6:5 have no effect.
- R4: With stepping disabled, every data byte of the frame goes to the same register, so the last byte is the one that remains.
- R5: With stepping enabled, the pointer moves up by one after each data byte inside 01h-07h and inside 09h-10h. At 08h and at 11h it holds, so it never moves from 08h to 09h.
- R6: Data bytes aimed at 00h or at 12h-1Fh are discarded, and no output changes.
- R7: If `csN` rises in the middle of a byte, those bits are dropped. The next frame starts again with the header.
- R8: The freeze flag is bit 1 of register 02h. While it is 1 in the live bank, writes are held in a staging bank and the output bus keeps its value.
- R9: When a write clears the freeze flag, every staged value appears on `regBus` in the same clock cycle.
- R10: The freeze flag always takes effect as soon as it is written. The other bits of register 02h are staged like any other register.
- R11: After reset every register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock. It oversamples the serial pins. |
| rstN | input | 1 | Active-low asynchronous reset. |
| csN | input | 1 | Active-low frame select. |
| sclk | input | 1 | Serial bit clock. |
| sdi | input | 1 | Serial data input. |
| regBus | output | 136 | Live registers. Register n sits at bits [(n-1)*8 +: 8], for n from 1 to 17. |

## Verification
If the pointer state is wrong, the effect shows up one frame later: a data byte lands on a neighbouring register, or lands on 09h after a run that ended at 08h. The bench detects this by reading the whole bus after every frame. If the bit counter or the header state is wrong, a bad or partial frame leaks into a register, and this is visible as soon as select is released. A wrong freeze state makes outputs move during a frozen frame, or makes the release arrive piecemeal. The bench therefore compares the complete bus after each frame of a freeze sequence.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 5;
  localparam int FIRST_REG  = 1;
  localparam int SEG1_LAST  = 8;
  localparam int LAST_REG   = 17;
  localparam int NUM_REGS   = LAST_REG - FIRST_REG + 1;
  localparam int ID_W       = 7;
  localparam logic [ID_W-1:0] CHIP_ID = 7'b0011000;
  localparam int FREEZE_REG = 2;
  localparam int FREEZE_BIT = 1;
  localparam int FREEZE_IDX = FREEZE_REG - FIRST_REG;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } wrStrobe_t;

  typedef enum logic [1:0] {ST_HDR, ST_PTR, ST_DATA, ST_SKIP} frameState_t;
endpackage

// File: rtl/spi_wr_ctrl.sv
module spi_wr_ctrl
  import spi_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output wrStrobe_t  strobe
);
  localparam int CNT_W = $clog2(REG_W);

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, datPipe;
  logic csS, clkS, datS, sclkPrev, sclkRise;
  logic [CNT_W-1:0] bitCnt;
  logic [REG_W-2:0] shiftQ;
  logic [REG_W-1:0] byteVal;
  logic [ADDR_W-1:0] ptr;
  logic incEn;
  frameState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      clkPipe  <= '0;
      datPipe  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      clkPipe  <= {clkPipe[SYNC_STAGES-2:0], sclk};
      datPipe  <= {datPipe[SYNC_STAGES-2:0], sdi};
      sclkPrev <= clkS;
    end
  end

  assign csS      = csPipe[SYNC_STAGES-1];
  assign clkS     = clkPipe[SYNC_STAGES-1];
  assign datS     = datPipe[SYNC_STAGES-1];
  assign sclkRise = clkS && !sclkPrev && !csS;
  assign byteVal  = {shiftQ, datS};

  function automatic logic inRange(input logic [ADDR_W-1:0] a);
    return (int'(a) >= FIRST_REG) && (int'(a) <= LAST_REG);
  endfunction

  function automatic logic canStep(input logic [ADDR_W-1:0] a);
    return ((int'(a) >= FIRST_REG) && (int'(a) < SEG1_LAST)) ||
           ((int'(a) > SEG1_LAST) && (int'(a) < LAST_REG));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HDR;
      bitCnt <= '0;
      shiftQ <= '0;
      ptr    <= '0;
      incEn  <= 1'b0;
      strobe <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (csS) begin
        state  <= ST_HDR;
        bitCnt <= '0;
      end else if (sclkRise) begin
        shiftQ <= byteVal[REG_W-2:0];
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(REG_W-1)) begin
          unique case (state)
            ST_HDR:  state <= (byteVal == {CHIP_ID, 1'b0}) ? ST_PTR : ST_SKIP;
            ST_PTR: begin
              incEn <= byteVal[REG_W-1];
              ptr   <= byteVal[ADDR_W-1:0];
              state <= ST_DATA;
            end
            ST_DATA: begin
              if (inRange(ptr)) begin
                strobe.wrEn <= 1'b1;
                strobe.addr <= ptr;
                strobe.data <= byteVal;
              end
              if (incEn && canStep(ptr)) ptr <= ptr + 1'b1;
            end
            default: state <= ST_SKIP;
          endcase
        end
      end
    end
  end

  assert_strobe_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(strobe.addr) >= FIRST_REG && int'(strobe.addr) <= LAST_REG));
  assert_ptr_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && !incEn |-> ptr == strobe.addr);
  assert_no_cross_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && incEn && (int'(strobe.addr) == SEG1_LAST || int'(strobe.addr) == LAST_REG)
      |-> ptr == strobe.addr);
  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && incEn && int'(strobe.addr) != SEG1_LAST && int'(strobe.addr) != LAST_REG
      |-> ptr == strobe.addr + 1'b1);
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !strobe.wrEn);
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SKIP |-> !strobe.wrEn);
endmodule

// File: rtl/spi_wr_regs.sv
module spi_wr_regs
  import spi_wr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobe_t                 strobe,
  output logic [NUM_REGS*REG_W-1:0] regBus
);
  logic [REG_W-1:0] staged [NUM_REGS];
  logic [REG_W-1:0] live   [NUM_REGS];
  logic [REG_W-1:0] stagedNext [NUM_REGS];
  logic frozenNow, frozenNext;
  int   wIdx;

  assign frozenNow = live[FREEZE_IDX][FREEZE_BIT];
  assign wIdx      = int'(strobe.addr) - FIRST_REG;

  always_comb begin
    stagedNext = staged;
    frozenNext = frozenNow;
    if (strobe.wrEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (i == wIdx) stagedNext[i] = strobe.data;
      if (int'(strobe.addr) == FREEZE_REG) frozenNext = strobe.data[FREEZE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        staged[i] <= '0;
        live[i]   <= '0;
      end
    end else if (strobe.wrEn) begin
      staged <= stagedNext;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (!frozenNext) live[i] <= stagedNext[i];
        else if (i == FREEZE_IDX) live[i][FREEZE_BIT] <= frozenNext;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gOut
    assign regBus[g*REG_W +: REG_W] = live[g];
    assert_commit_match_R9: assert property (@(posedge clk) disable iff (!rstN)
      !frozenNow |-> live[g] == staged[g]);
  end

  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && frozenNow && int'(strobe.addr) != FREEZE_REG |=> $stable(regBus));
  assert_freeze_direct_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && int'(strobe.addr) == FREEZE_REG |=> frozenNow == $past(strobe.data[FREEZE_BIT]));
endmodule

// File: rtl/spi_wr_port.sv
module spi_wr_port
  import spi_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      sdi,
  output logic [NUM_REGS*REG_W-1:0] regBus
);
  wrStrobe_t strobe;

  spi_wr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .strobe(strobe)
  );

  spi_wr_regs regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regBus(regBus)
  );
endmodule

// File: tb/spi_wr_port_tb.sv
module spi_wr_port_tb_top;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [17*8-1:0] regBus;
  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 1'b0;

  logic [7:0] txBuf [0:15];
  logic [7:0] mStaged [1:17];
  logic [7:0] mLive   [1:17];
  bit mFrozen = 1'b0;

  always #2 clk = ~clk;

  spi_wr_port dut_i (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .regBus(regBus));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBit(input logic b);
    sdi = b;
    waitClk(4);
    sclk = 1'b1;
    waitClk(4);
    sclk = 1'b0;
  endtask

  // R1: bytes go out MSB first, on rising sclk while csN is low
  task automatic sendFrame(input int nBytes, input int extraBits);
    csN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nBytes; i++)
      for (int b = 7; b >= 0; b--) spiBit(txBuf[i][b]);
    for (int b = 0; b < extraBits; b++) spiBit(b[0]);
    waitClk(4);
    csN = 1'b1;
    waitClk(10);
  endtask

  // Model built from R5, R6, R8, R9 and R10
  task automatic modelWrite(input int a, input logic [7:0] d);
    if (a < 1 || a > 17) return;
    mStaged[a] = d;
    if (a == 2) mFrozen = d[1];
    if (!mFrozen) begin
      for (int n = 1; n <= 17; n++) mLive[n] = mStaged[n];
    end else begin
      mLive[2][1] = 1'b1;
    end
  endtask

  function automatic int stepPtr(input int a);
    if ((a >= 1 && a < 8) || (a > 8 && a < 17)) return a + 1;
    return a;
  endfunction

  task automatic checkAll(input string req);
    for (int n = 1; n <= 17; n++) begin
      nChecks++;
      if (regBus[(n-1)*8 +: 8] !== mLive[n]) begin
        nFails++;
        $display("FAIL %s reg %0d: actual %02h expected %02h", req, n, regBus[(n-1)*8 +: 8], mLive[n]);
      end
    end
  endtask

  task automatic dataFrame(input logic inc, input int p, input logic [1:0] junk,
                           input int nData, input logic [7:0] seed);
    int a;
    txBuf[0] = 8'h30;
    txBuf[1] = {inc, junk, 5'(p)};
    a = p;
    for (int k = 0; k < nData; k++) begin
      txBuf[2+k] = seed + 8'(k * 7);
      modelWrite(a, txBuf[2+k]);
      if (inc) a = stepPtr(a);
    end
    sendFrame(2 + nData, 0);
  endtask

  initial begin
    for (int n = 1; n <= 17; n++) begin
      mStaged[n] = 8'h00;
      mLive[n] = 8'h00;
    end
    waitClk(5);
    checkAll("R11");
    rstN = 1'b1;
    waitClk(5);
    checkAll("R11");

    // R4 R5 R6 R3: sweep every pointer value with and without stepping
    for (int inc = 0; inc < 2; inc++)
      for (int p = 0; p < 32; p++) begin
        dataFrame(inc[0], p, 2'(p), 3, 8'(p * 29 + inc * 101 + 3) & 8'hFD);
        checkAll(inc != 0 ? "R5" : "R4");
      end

    // R5: a long run from 01h piles up at 08h
    dataFrame(1'b1, 1, 2'b00, 10, 8'h41);
    checkAll("R5");
    dataFrame(1'b1, 15, 2'b11, 4, 8'h11);
    checkAll("R5");

    // R2: a read header and a foreign identity leave the registers untouched
    txBuf[0] = 8'h31; txBuf[1] = 8'h01; txBuf[2] = 8'hA5;
    sendFrame(3, 0);
    checkAll("R2");
    txBuf[0] = 8'h32;
    sendFrame(3, 0);
    checkAll("R2");

    // R7: a partial trailing byte is dropped and the next frame re-aligns
    txBuf[0] = 8'h30; txBuf[1] = 8'h85; txBuf[2] = 8'h5C;
    modelWrite(5, 8'h5C);
    sendFrame(3, 5);
    checkAll("R7");
    dataFrame(1'b0, 6, 2'b00, 1, 8'h99);
    checkAll("R7");

    // R8: freeze, then write several registers
    dataFrame(1'b0, 2, 2'b00, 1, 8'h02);
    checkAll("R8");
    dataFrame(1'b1, 9, 2'b00, 4, 8'h70);
    checkAll("R8");
    // R10: the freeze bit is live at once, bit 2 of 02h waits
    dataFrame(1'b0, 2, 2'b00, 1, 8'h06);
    checkAll("R10");
    dataFrame(1'b1, 3, 2'b00, 3, 8'hC0);
    checkAll("R8");
    // R9: release freeze, and all staged values appear together
    dataFrame(1'b0, 2, 2'b00, 1, 8'h44);
    checkAll("R9");
    // R6: out-of-range writes while frozen and after release stay invisible
    dataFrame(1'b0, 2, 2'b00, 1, 8'h02);
    dataFrame(1'b0, 18, 2'b00, 2, 8'hEE);
    dataFrame(1'b0, 0, 2'b00, 2, 8'hEE);
    dataFrame(1'b0, 2, 2'b00, 1, 8'h00);
    checkAll("R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule